// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block sequences a 12-bit successive-approximation converter. After reset it runs a fixed-length power-up calibration window. It then accepts one-cycle start requests that carry a 5-bit channel number. Each accepted request runs a sample phase and then a bit-serial approximation. The approximation drives a trial code toward the analog side and reads back a single comparator bit. It keeps one result bit per cycle, starting with the MSB. The finished code is latched together with its channel, and `dataValid` flags it.

A new start that arrives while a conversion is running abandons that conversion and begins a fresh one. After every completed conversion there is a single-cycle post-calibration slot. In that slot the comparator bit moves one of thirteen 8-bit trim registers up or down by one. The slots are the offset trim and one trim for each main-array bit, and they are visited in a fixed rotation. A power-down input blocks new conversions. A sticky warning records any start accepted while power-up calibration was still running.

Top module: `sar_seq_top`

## Requirements
- R1: After reset is released, `calActive` is high for exactly CAL_CYCLES clock cycles, then stays low until the next reset. Starts are accepted during this window and convert normally.
- R2: A start is accepted on a rising edge where `startPulse` is high and the start is not blocked (R8, R11). On the accepting edge `chanIn` is captured, and `sampling` and `busy` go high. `sampling` stays high for SAMPLE_CYCLES cycles and then falls while `busy` stays high.
- R3: After sampling, the bits are resolved one per cycle from bit 11 down to bit 0. During each such cycle `dacCode` equals the bits already kept, OR-ed with the bit under test. The tested bit is kept when `compIn` is 1. Outside these cycles `dacCode` is 0.
- R4: On the edge that resolves bit 0, `busy` falls and `dataValid` rises. On the same edge `result` takes the resolved code and `resultChan` takes the captured channel. This is SAMPLE_CYCLES+12 edges after the accepting edge.
- R5: `dataValid` stays high until the edge that accepts the next start. It is low from that edge on.
- R6: `result` changes only on an edge where `dataValid` rises.
- R7: A start accepted during sampling or conversion restarts sampling on its accepting edge. The abandoned conversion never reaches `result`.
- R8: A start less than MIN_GAP cycles after the previous accepted start is ignored.
- R9: Trim slot k occupies `trimBus` bits [k*TRIM_BITS +: TRIM_BITS], and reset sets every trim to midscale (MSB only set). In the cycle after completion, the trim of the current slot increments if `compIn` is 1 and decrements if it is 0. It saturates at all-ones and at zero.
- R10: `postCalSlot` names the slot trimmed next: 0 is the offset, and 1 to 12 are main-array bits 11 down to 0. It advances by one after each trim and wraps from 12 to 0. A start accepted on the post-calibration edge skips that trim and leaves the slot unchanged.
- R11: While `powerDown` is high, starts are ignored and outputs keep their values.
- R12: `earlyStartWarn` is set by a start accepted while `calActive` is high, and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | One-cycle conversion request |
| chanIn | input | 5 | Channel number for the request |
| powerDown | input | 1 | Comparator disabled; blocks starts |
| compIn | input | 1 | Comparator decision for the current `dacCode` |
| sampling | output | 1 | Sample phase in progress |
| busy | output | 1 | Sample or approximation in progress |
| dataValid | output | 1 | `result` holds a finished conversion |
| result | output | 12 | Latched conversion code |
| resultChan | output | 5 | Channel of the latched code |
| dacCode | output | 12 | Trial code during approximation, else 0 |
| calActive | output | 1 | Power-up calibration window |
| earlyStartWarn | output | 1 | Sticky: start accepted during calibration |
| postCalSlot | output | 4 | Next post-calibration slot |
| trimBus | output | 104 | All thirteen trim registers, slot k at k*8 |

## Verification
The bench builds the block with CAL_CYCLES=20, SAMPLE_CYCLES=3 and TRIM_BITS=3, keeping MIN_GAP at 2. The short calibration window lets the bench measure its exact length and also issue a start inside it. Three-bit trims start at 4, so a few dozen conversions drive every slot into both saturation limits. The comparator is modelled in the bench as `dacCode <= vin`, so every resolved code can be predicted from the chosen input.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV,
    ST_POSTCAL
  } seqState_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic beginConv;  // accepted start: capture channel, clear code
    logic enterConv;  // last sample cycle: arm MSB trial
    logic bitStep;    // resolve one bit this cycle
    logic finish;     // bit 0 resolved: publish result
    logic trimStep;   // post-calibration cycle
  } seqStrobe_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int CAL_CYCLES    = 3840,
  parameter int SAMPLE_CYCLES = 4,
  parameter int MIN_GAP       = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       powerDown,
  input  logic       lastBit,
  output seqStrobe_t strb,
  output logic       sampling,
  output logic       busy,
  output logic       dataValid,
  output logic       calActive,
  output logic       earlyStartWarn
);

  localparam int SCW = $clog2(SAMPLE_CYCLES + 1);
  localparam int CCW = $clog2(CAL_CYCLES + 1);
  localparam int GCW = $clog2(MIN_GAP + 1);

  seqState_e       state;
  logic [SCW-1:0]  sampCnt;
  logic [CCW-1:0]  calCnt;
  logic [GCW-1:0]  gapCnt;
  logic            accept;

  assign accept    = startPulse && !powerDown && (gapCnt == '0);
  assign calActive = (calCnt != '0);
  assign sampling  = (state == ST_SAMPLE);
  assign busy      = (state == ST_SAMPLE) || (state == ST_CONV);

  always_comb begin
    strb = '0;
    if (accept) begin
      strb.beginConv = 1'b1;
    end else begin
      case (state)
        ST_SAMPLE:  strb.enterConv = (sampCnt == '0);
        ST_CONV: begin
          strb.bitStep = 1'b1;
          strb.finish  = lastBit;
        end
        ST_POSTCAL: strb.trimStep = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sampCnt <= '0;
    end else if (strb.beginConv) begin
      state   <= ST_SAMPLE;
      sampCnt <= SCW'(SAMPLE_CYCLES - 1);
    end else begin
      case (state)
        ST_SAMPLE: begin
          if (strb.enterConv) state <= ST_CONV;
          else                sampCnt <= sampCnt - 1'b1;
        end
        ST_CONV:    if (strb.finish) state <= ST_POSTCAL;
        ST_POSTCAL: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calCnt <= CCW'(CAL_CYCLES);
    end else if (calCnt != '0) begin
      calCnt <= calCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (accept) begin
      gapCnt <= GCW'(MIN_GAP - 1);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid      <= 1'b0;
      earlyStartWarn <= 1'b0;
    end else begin
      if (strb.beginConv)   dataValid <= 1'b0;
      else if (strb.finish) dataValid <= 1'b1;
      if (strb.beginConv && calActive) earlyStartWarn <= 1'b1;
    end
  end

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS  = 12,
  parameter int CHAN_BITS = 5,
  parameter int TRIM_BITS = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  seqStrobe_t                        strb,
  input  logic [CHAN_BITS-1:0]              chanIn,
  input  logic                              compIn,
  output logic                              lastBit,
  output logic [RES_BITS-1:0]               dacCode,
  output logic [RES_BITS-1:0]               result,
  output logic [CHAN_BITS-1:0]              resultChan,
  output logic [(RES_BITS+1)*TRIM_BITS-1:0] trimBus,
  output logic [$clog2(RES_BITS+1)-1:0]     postCalSlot
);

  localparam int SLOTS = RES_BITS + 1;
  localparam int IDXW  = $clog2(RES_BITS);
  localparam int SLOTW = $clog2(SLOTS);
  localparam logic [TRIM_BITS-1:0] TRIM_MID = {1'b1, {(TRIM_BITS-1){1'b0}}};
  localparam logic [TRIM_BITS-1:0] TRIM_MAX = '1;

  logic [RES_BITS-1:0]  sarReg;
  logic [RES_BITS-1:0]  testBit;
  logic [IDXW-1:0]      bitIdx;
  logic [CHAN_BITS-1:0] chanHeld;
  logic [SLOTW-1:0]     slot;

  assign testBit     = RES_BITS'(1) << bitIdx;
  assign lastBit     = (bitIdx == '0);
  assign dacCode     = strb.bitStep ? (sarReg | testBit) : '0;
  assign postCalSlot = slot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg   <= '0;
      bitIdx   <= '0;
      chanHeld <= '0;
    end else if (strb.beginConv) begin
      sarReg   <= '0;
      bitIdx   <= IDXW'(RES_BITS - 1);
      chanHeld <= chanIn;
    end else if (strb.enterConv) begin
      sarReg <= '0;
      bitIdx <= IDXW'(RES_BITS - 1);
    end else if (strb.bitStep) begin
      if (compIn) sarReg <= sarReg | testBit;
      if (bitIdx != '0) bitIdx <= bitIdx - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result     <= '0;
      resultChan <= '0;
    end else if (strb.finish) begin
      result     <= compIn ? (sarReg | testBit) : sarReg;
      resultChan <= chanHeld;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot <= '0;
    end else if (strb.trimStep) begin
      slot <= (slot == SLOTW'(SLOTS - 1)) ? '0 : slot + 1'b1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gTrim
    logic [TRIM_BITS-1:0] trimReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        trimReg <= TRIM_MID;
      end else if (strb.trimStep && (slot == SLOTW'(g))) begin
        if (compIn && (trimReg != TRIM_MAX))     trimReg <= trimReg + 1'b1;
        else if (!compIn && (trimReg != '0))     trimReg <= trimReg - 1'b1;
      end
    end
    assign trimBus[g*TRIM_BITS +: TRIM_BITS] = trimReg;
  end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS      = 12,
  parameter int CHAN_BITS     = 5,
  parameter int TRIM_BITS     = 8,
  parameter int CAL_CYCLES    = 3840,
  parameter int SAMPLE_CYCLES = 4,
  parameter int MIN_GAP       = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              startPulse,
  input  logic [CHAN_BITS-1:0]              chanIn,
  input  logic                              powerDown,
  input  logic                              compIn,
  output logic                              sampling,
  output logic                              busy,
  output logic                              dataValid,
  output logic [RES_BITS-1:0]               result,
  output logic [CHAN_BITS-1:0]              resultChan,
  output logic [RES_BITS-1:0]               dacCode,
  output logic                              calActive,
  output logic                              earlyStartWarn,
  output logic [$clog2(RES_BITS+1)-1:0]     postCalSlot,
  output logic [(RES_BITS+1)*TRIM_BITS-1:0] trimBus
);

  seqStrobe_t strb;
  logic       lastBit;

  sar_seq_ctrl #(
    .CAL_CYCLES   (CAL_CYCLES),
    .SAMPLE_CYCLES(SAMPLE_CYCLES),
    .MIN_GAP      (MIN_GAP)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .startPulse    (startPulse),
    .powerDown     (powerDown),
    .lastBit       (lastBit),
    .strb          (strb),
    .sampling      (sampling),
    .busy          (busy),
    .dataValid     (dataValid),
    .calActive     (calActive),
    .earlyStartWarn(earlyStartWarn)
  );

  sar_seq_dp #(
    .RES_BITS (RES_BITS),
    .CHAN_BITS(CHAN_BITS),
    .TRIM_BITS(TRIM_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .chanIn     (chanIn),
    .compIn     (compIn),
    .lastBit    (lastBit),
    .dacCode    (dacCode),
    .result     (result),
    .resultChan (resultChan),
    .trimBus    (trimBus),
    .postCalSlot(postCalSlot)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rstN,
  input seqStrobe_t          strb,
  input logic                powerDown,
  input logic                sampling,
  input logic                busy,
  input logic                dataValid,
  input logic                calActive,
  input logic [RES_BITS-1:0] result
);

  // R1
  cal_no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(calActive));

  // R2
  start_opens_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beginConv |=> (sampling && busy && !dataValid));

  // R4
  busy_fall_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && !sampling |-> dataValid);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(dataValid) |-> $stable(result));

  // R8
  start_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beginConv |=> !strb.beginConv);

  // R11
  powerdown_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> !strb.beginConv);

endmodule

bind sar_seq_top sar_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .powerDown(powerDown),
  .sampling (sampling),
  .busy     (busy),
  .dataValid(dataValid),
  .calActive(calActive),
  .result   (result)
);

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;

  localparam int RB    = 12;
  localparam int CB    = 5;
  localparam int TB    = 3;
  localparam int CAL   = 20;
  localparam int SAMP  = 3;
  localparam int SLOTS = RB + 1;
  localparam int TMAX  = (1 << TB) - 1;
  localparam int TMID  = 1 << (TB - 1);

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               startPulse = 1'b0;
  logic [CB-1:0]      chanIn = '0;
  logic               powerDown = 1'b0;
  logic               compIn;
  logic               sampling, busy, dataValid, calActive, earlyStartWarn;
  logic [RB-1:0]      result, dacCode;
  logic [CB-1:0]      resultChan;
  logic [3:0]         postCalSlot;
  logic [SLOTS*TB-1:0] trimBus;

  logic [RB-1:0] vin = '0;
  logic          ovrEn = 1'b0;
  logic          ovrVal = 1'b0;

  assign compIn = ovrEn ? ovrVal : (dacCode <= vin);

  always #2.5 clk = ~clk;

  sar_seq_top #(
    .TRIM_BITS(TB), .CAL_CYCLES(CAL), .SAMPLE_CYCLES(SAMP), .MIN_GAP(2)
  ) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chanIn(chanIn),
    .powerDown(powerDown), .compIn(compIn), .sampling(sampling), .busy(busy),
    .dataValid(dataValid), .result(result), .resultChan(resultChan),
    .dacCode(dacCode), .calActive(calActive), .earlyStartWarn(earlyStartWarn),
    .postCalSlot(postCalSlot), .trimBus(trimBus)
  );

  int nChecks = 0;
  int nFails  = 0;
  int trimExp [SLOTS];
  int slotExp;
  bit done = 1'b0;

  // chan(5) | vin(12) | decrement flag(1)
  localparam logic [17:0] VEC [8] = '{
    {5'd0,  12'h000, 1'b0}, {5'd31, 12'hFFF, 1'b0},
    {5'd4,  12'h800, 1'b1}, {5'd9,  12'h7FF, 1'b0},
    {5'd17, 12'hAAA, 1'b1}, {5'd22, 12'h555, 1'b0},
    {5'd1,  12'h001, 1'b1}, {5'd30, 12'hFFE, 1'b0}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [SLOTS*TB-1:0] trimPack();
    logic [SLOTS*TB-1:0] v;
    for (int k = 0; k < SLOTS; k++) v[k*TB +: TB] = TB'(trimExp[k]);
    return v;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < SLOTS; k++) trimExp[k] = TMID;
    slotExp = 0;
  endtask

  task automatic modelTrim(bit up);
    if (up && trimExp[slotExp] < TMAX) trimExp[slotExp]++;
    else if (!up && trimExp[slotExp] > 0) trimExp[slotExp]--;
    slotExp = (slotExp + 1) % SLOTS;
  endtask

  // Called at a falling edge; returns half a cycle after the accepting edge
  task automatic doStart(logic [CB-1:0] ch);
    startPulse = 1'b1;
    chanIn = ch;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic runConv(logic [CB-1:0] ch, logic [RB-1:0] v, bit dec);
    logic [RB-1:0] prevRes;
    prevRes = result;
    vin = v;
    doStart(ch);
    chk("R2 sampling after start", sampling, 1);
    chk("R5 busy/valid after start", {busy, dataValid}, 2'b10);
    chk("R6 result held during conversion", result, prevRes);
    repeat (SAMP) @(negedge clk);
    chk("R2 sampling ends", {sampling, busy}, 2'b01);
    chk("R3 first trial is MSB", dacCode, 12'h800);
    repeat (RB) @(negedge clk);
    chk("R4 completion flags", {busy, dataValid}, 2'b01);
    chk("R4 result code", result, v);
    chk("R4 result channel", resultChan, ch);
    if (dec) begin
      ovrEn = 1'b1;
      ovrVal = 1'b0;
    end
    @(negedge clk);
    ovrEn = 1'b0;
    modelTrim(!dec);
    chk("R9 trim update", trimBus, trimPack());
    chk("R10 slot advance", postCalSlot, slotExp);
    chk("R3 trial code idle", dacCode, 0);
    chk("R5 valid holds", dataValid, 1);
  endtask

  initial begin
    modelReset();
    // Reset state
    repeat (3) @(negedge clk);
    chk("R1 cal active in reset", calActive, 1);
    chk("R4 idle flags in reset", {sampling, busy, dataValid}, 3'b000);
    chk("R9 trims midscale at reset", trimBus, trimPack());
    chk("R10 slot zero at reset", postCalSlot, 0);
    chk("R12 warn clear at reset", earlyStartWarn, 0);
    rstN = 1'b1;
    begin
      int n = 0;
      while (calActive && n < 1000) begin
        n++;
        @(negedge clk);
      end
      chk("R1 calibration length", n, CAL);
    end
    repeat (5) @(negedge clk);
    chk("R1 calibration stays done", calActive, 0);

    // Vector table
    for (int i = 0; i < 8; i++)
      runConv(VEC[i][17:13], VEC[i][12:1], VEC[i][0]);
    chk("R12 no warning after calibration", earlyStartWarn, 0);

    // R7 abort mid-conversion
    begin
      logic [RB-1:0] held;
      held = result;
      vin = 12'd100;
      doStart(5'd1);
      repeat (SAMP + 5) @(negedge clk);
      vin = 12'd3000;
      doStart(5'd2);
      chk("R7 restart sampling", {sampling, busy, dataValid}, 3'b110);
      chk("R7 abandoned code not published", result, held);
      repeat (SAMP + RB) @(negedge clk);
      chk("R7 second result", result, 12'd3000);
      chk("R7 second channel", resultChan, 5'd2);
      @(negedge clk);
      modelTrim(1);
      chk("R9 trim after abort", trimBus, trimPack());
    end

    // R8 back-to-back start pulses: the second is ignored
    vin = 12'd1234;
    startPulse = 1'b1;
    chanIn = 5'd5;
    @(negedge clk);
    chanIn = 5'd6;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (SAMP + RB - 1) @(negedge clk);
    chk("R8 second pulse ignored: valid timing", dataValid, 1);
    chk("R8 second pulse ignored: channel", resultChan, 5'd5);
    chk("R8 result", result, 12'd1234);
    @(negedge clk);
    modelTrim(1);

    // R11 power-down blocks a start
    powerDown = 1'b1;
    doStart(5'd7);
    repeat (3) @(negedge clk);
    chk("R11 no start while powered down", {sampling, busy, dataValid}, 3'b001);
    chk("R11 channel unchanged", resultChan, 5'd5);
    powerDown = 1'b0;
    @(negedge clk);

    // R10 start on the post-calibration edge skips the trim
    vin = 12'd222;
    doStart(5'd11);
    repeat (SAMP + RB) @(negedge clk);
    chk("R4 result before skip", result, 12'd222);
    vin = 12'd333;
    doStart(5'd12);
    chk("R10 slot unchanged when trim skipped", postCalSlot, slotExp);
    chk("R10 trims unchanged when trim skipped", trimBus, trimPack());
    chk("R10 new sample running", sampling, 1);
    repeat (SAMP + RB) @(negedge clk);
    chk("R4 result after skip", result, 12'd333);
    @(negedge clk);
    modelTrim(1);
    chk("R10 trim applied on next slot", trimBus, trimPack());

    // R9 saturation both ways
    for (int r = 0; r < 5 * SLOTS; r++) runConv(CB'(r), RB'((r * 311) % 4096), 0);
    chk("R9 saturate high", trimBus, {SLOTS*TB{1'b1}});
    for (int r = 0; r < 9 * SLOTS; r++) runConv(CB'(r + 3), RB'((r * 577) % 4096), 1);
    chk("R9 saturate low", trimBus, '0);

    // R12 start during calibration
    rstN = 1'b0;
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 calibration running", calActive, 1);
    runConv(5'd3, 12'd777, 0);
    chk("R12 warning set", earlyStartWarn, 1);
    repeat (CAL) @(negedge clk);
    chk("R12 warning sticky", earlyStartWarn, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule